// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands over several clock cycles using a single adder that is only one operand wide. When it accepts an operation, it stores the multiplicand in a register. It places the multiplier in the lower half of a double-width product register and clears the upper half. On each step, the low bit of the product register decides whether the multiplicand is added into the upper half. The whole register, including the adder's carry-out, then moves one place to the right. After one step per multiplier bit, the upper and lower halves of the register hold the full double-width product.

The block is controlled by a simple handshake. A caller raises `start` for one cycle while `busy` is low. `busy` then stays high while the steps run. `done` pulses for one cycle when the result is ready. The result stays on `hi` and `lo` until the next operation is accepted. The operands are captured when `start` is accepted, so the caller can reuse the input buses right away.

Top module: `seqmul_unit`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0 and `hi` and `lo` are all zeros.
- R2: `start` is accepted only at a clock edge where `busy` is 0. In the cycle that follows an accepted start, `busy` is 1.
- R3: After an accepted start, `busy` stays 1 for exactly WIDTH consecutive cycles and then falls.
- R4: `done` is 1 for exactly one cycle: the first cycle after `busy` falls. `done` and `busy` are never 1 in the same cycle.
- R5: When `done` is 1, `{hi, lo}` equals the unsigned product of the two operands sampled at the accepted start. `hi` is the upper WIDTH bits and `lo` is the lower WIDTH bits.
- R6: While `busy` is 1, changes on `mcand_in` and `mplier_in`, and any assertion of `start`, have no effect on the operation in progress or on its result.
- R7: While idle and with no accepted start, `hi` and `lo` keep their last value.
- R8: No carry is lost from the upper half. Operands of all ones give the product (2^WIDTH-1)^2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new multiplication; honoured only when not busy |
| mcand_in | input | WIDTH | Multiplicand operand |
| mplier_in | input | WIDTH | Multiplier operand |
| busy | output | 1 | High while the shift-add steps run |
| done | output | 1 | One-cycle pulse marking a valid result |
| hi | output | WIDTH | Upper half of the product |
| lo | output | WIDTH | Lower half of the product |

## Verification
Assertions run on every cycle. They check the handshake: busy follows an idle start, done always follows the final step and never overlaps busy, and done lasts only one cycle. They also check the datapath: a zero low bit only halves the upper half, the stored multiplicand does not move during a run, and the result holds while idle. Only the bench's scenarios can show that the product itself is right. It sweeps every operand pair of a narrow configuration, including the all-ones carry case. The same sweep shows that busy lasts exactly WIDTH cycles and that input noise and repeated start requests during a run leave the result untouched.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seqmul_state_e;

    // width of a step counter able to hold values 0 .. steps-1
    function automatic int step_cnt_width(input int steps);
        return (steps > 1) ? $clog2(steps) : 1;
    endfunction

endpackage

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
    import seqmul_pkg::*;
#(
    parameter int STEPS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CNT_W = step_cnt_width(STEPS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    seqmul_state_e    state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    assign load = start && (state_q == ST_IDLE);
    assign step = (state_q == ST_RUN);
    assign busy = step;
    assign done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                ST_RUN: begin
                    if (cnt_q == LAST) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_RUN_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt_q != LAST) |=> (busy && cnt_q == $past(cnt_q) + 1'b1)); // R3
    AST_LAST_STEP_ENDS: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt_q == LAST) |=> (!busy && done)); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R4

endmodule

// File: rtl/seqmul_datapath.sv
module seqmul_datapath #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] mcand_in,
    input  logic [WIDTH-1:0] mplier_in,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo
);
    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0] mcand_q;
    logic [PW-1:0]    prod_q;
    logic [WIDTH:0]   addend;
    logic [WIDTH:0]   upper_sum;
    logic [PW-1:0]    prod_next;

    // one WIDTH-bit add with its carry kept as bit WIDTH
    always_comb begin
        addend    = prod_q[0] ? {1'b0, mcand_q} : '0;
        upper_sum = {1'b0, prod_q[PW-1:WIDTH]} + addend;
        prod_next = {upper_sum, prod_q[WIDTH-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            prod_q  <= {{WIDTH{1'b0}}, mplier_in};
        end else if (step) begin
            prod_q  <= prod_next;
        end
    end

    assign hi = prod_q[PW-1:WIDTH];
    assign lo = prod_q[WIDTH-1:0];

    AST_SKIP_ONLY_SHIFTS: assert property (@(posedge clk) disable iff (rst)
        (step && !lo[0]) |=> (hi == ($past(hi) >> 1))); // R5
    AST_LOAD_CLEARS_UPPER: assert property (@(posedge clk) disable iff (rst)
        load |=> (hi == '0 && lo == $past(mplier_in))); // R5

endmodule

// File: rtl/seqmul_unit.sv
module seqmul_unit #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] mcand_in,
    input  logic [WIDTH-1:0] mplier_in,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo
);
    logic load;
    logic step;

    seqmul_ctrl #(.STEPS(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    seqmul_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (step),
        .mcand_in  (mcand_in),
        .mplier_in (mplier_in),
        .hi        (hi),
        .lo        (lo)
    );

    AST_IDLE_START_RUNS: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R2
    AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done); // R4
    AST_MCAND_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(u_dp.mcand_q)); // R6
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(hi) && $stable(lo))); // R7

endmodule

// File: tb/seqmul_unit_test.sv
module seqmul_unit_test;
    localparam int W = 6;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [W-1:0] mcand_in;
    logic [W-1:0] mplier_in;
    logic         busy;
    logic         done;
    logic [W-1:0] hi;
    logic [W-1:0] lo;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    seqmul_unit #(.WIDTH(W)) uut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mcand_in  (mcand_in),
        .mplier_in (mplier_in),
        .busy      (busy),
        .done      (done),
        .hi        (hi),
        .lo        (lo)
    );

    task automatic check(input string req, input logic [2*W-1:0] act,
                         input logic [2*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit disturb);
        logic [2*W-1:0] expv;
        int cycles;
        expv = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        @(negedge clk);
        start = 1'b1; mcand_in = a; mplier_in = b;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", {{(2*W-1){1'b0}}, busy}, 1);
        cycles = 0;
        while (busy && cycles < 100) begin
            if (disturb) begin
                // R6: noise and extra start while running
                mcand_in  = ~a ^ W'(cycles);
                mplier_in = b + W'(cycles + 1);
                start     = 1'b1;
            end
            @(negedge clk);
            cycles++;
        end
        start = 1'b0;
        check("R3 busy length", 2*W'(cycles), 2*W'(W));
        check("R4 done after busy", {{(2*W-1){1'b0}}, done}, 1);
        check(disturb ? "R6 product under noise" : "R5 product", {hi, lo}, expv);
        @(negedge clk);
        check("R4 done single cycle", {{(2*W-1){1'b0}}, done}, 0);
        check("R7 result held", {hi, lo}, expv);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; mcand_in = '0; mplier_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset busy", {{(2*W-1){1'b0}}, busy}, 0);
        check("R1 reset done", {{(2*W-1){1'b0}}, done}, 0);
        check("R1 reset product", {hi, lo}, 0);

        // R8: all-ones operands exercise the carry into the top bit
        run_op({W{1'b1}}, {W{1'b1}}, 1'b0);
        check("R8 max product", {hi, lo}, ((2*W)'(1) << W) * ((2*W)'(1) << W)
              - ((2*W)'(1) << (W + 1)) + 1);

        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                run_op(W'(a), W'(b), ((a ^ b) & 1) == 1);
            end
        end

        // R7: idle with moving inputs and no start keeps the result
        mcand_in = 6'h2A; mplier_in = 6'h15;
        repeat (4) @(negedge clk);
        check("R7 idle hold", {hi, lo}, 12'(63 * 63));

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule